// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM Core

This block is a synchronous static memory with 18-bit words held in an internal register array. Each word is split into two 9-bit lanes. Address, controls and write data are captured on rising clock edges. Reads and writes share one fixed two-edge pipeline, so a read can follow a write (or the reverse) on consecutive cycles without an idle slot on the data bus.

Each access starts with an external address load. A four-word burst is then continued by an advance control that steps the two low address bits in linear, wrapping order. Three chip-select inputs decide, at load time only, whether the access is for this device; burst continuations inherit that decision. An active-low clock enable freezes every register in the block. An active-low output enable gates the read-data valid flag and the read data combinationally. The data bus is modelled as a separate input word, output word and valid flag.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0, and no access is in flight.
- R2: A selected read command sampled at an enabled edge puts the word on `rdata` with `rvalid` high after the second enabled edge that follows it, provided `out_en_n` is 0.
- R3: The write data for a write command is taken from `wdata` at the second enabled edge after that command. Write and read commands may alternate on consecutive cycles, and each read returns every write issued before it.
- R4: `lane_wr_n[0]` guards word bits 8:0 and `lane_wr_n[1]` guards bits 17:9. A write changes only the lanes whose enable is 0.
- R5: With `burst_adv` = 1, the access address is the previous one with bits 1:0 incremented modulo 4 and the upper bits unchanged. The operation type (read or write) is inherited from the load, and `wr_n` is ignored.
- R6: The device is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 on a load cycle (`burst_adv`=0). A deselected access neither writes the array nor raises `rvalid`, and chip selects are ignored on advance cycles.
- R7: While `clk_en_n` is 1, no input is sampled and all pipeline state, `rdata` and `rvalid` hold their values.
- R8: While `out_en_n` is 1, `rvalid` is 0 and `rdata` is 0, with no clock delay.
- R9: A read issued on the cycle after a write to the same address returns the newly merged word, not the old array contents.
- R10: When the output stage does not hold a selected read (a write data phase, an idle or a deselected access), `rvalid` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| cs0_n | input | 1 | Active-low chip select, sampled on load cycles |
| cs1 | input | 1 | Active-high chip select, sampled on load cycles |
| cs2_n | input | 1 | Active-low chip select, sampled on load cycles |
| burst_adv | input | 1 | 1 = advance burst counter, 0 = load external address |
| wr_n | input | 1 | Active-low write command (high = read) |
| lane_wr_n | input | 2 | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data, sampled two enabled edges after the command |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| rdata | output | 18 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
A selected read returns its word after the second enabled edge following the command, and a write takes `wdata` at that same second edge. The bench keeps a two-entry model pipeline that advances only on edges where `clk_en_n` is 0. It drives `wdata` on the cycle when its model shows the write in the second stage, and compares `rdata`/`rvalid` one nanosecond after each edge against the word its reference memory holds for the read that has just reached stage two. Output-enable gating is combinational, so the bench checks it in the same sample, with no added delay.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              burst_adv,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lane_n,
  output logic              burst_live
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0] base_q, base_nx;
  logic              sel_q, sel_nx;
  logic              wr_q, wr_nx;
  logic [BURST_W-1:0] step;

  always_comb begin
    step    = base_q[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1};
    sel_nx  = sel_q;
    wr_nx   = wr_q;
    base_nx = {base_q[ADDR_W-1:BURST_W], step};
    if (!burst_adv) begin
      sel_nx  = ~cs0_n & cs1 & ~cs2_n;
      wr_nx   = ~wr_n;
      base_nx = addr;
    end
  end

  always_comb begin
    cmd_addr   = base_nx;
    cmd_lane_n = lane_wr_n;
    if (!sel_nx)    cmd_op = OP_IDLE;
    else if (wr_nx) cmd_op = OP_WRITE;
    else            cmd_op = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (en) begin
      base_q <= base_nx;
      sel_q  <= sel_nx;
      wr_q   <= wr_nx;
    end
  end

  assign burst_live = sel_q;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[l]) begin
        mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_lane_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [LANES-1:0]  mem_wlane,
  output logic [WORD_W-1:0] mem_wdata,
  output op_e               st1_op,
  output logic [ADDR_W-1:0] st1_addr,
  output op_e               st2_op,
  output logic              out_live,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  op_e               s1_op_q, s2_op_q;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [LANES-1:0]  s1_lane_q, s2_lane_q;
  logic [WORD_W-1:0] hold_q, hold_nx;
  logic [WORD_W-1:0] out_q, out_nx;
  logic              out_v_q, out_v_nx;
  logic [WORD_W-1:0] merged;
  logic              fwd;

  // Write committing at this edge, merged with the array word it updates.
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = s2_lane_q[l] ? mem_rdata[l*LANE_W +: LANE_W]
                                                     : wdata[l*LANE_W +: LANE_W];
  end

  always_comb begin
    fwd      = (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr_q);
    hold_nx  = hold_q;
    if (s1_op_q == OP_READ) hold_nx = fwd ? merged : mem_rdata;
    out_v_nx = (s2_op_q == OP_READ);
    out_nx   = out_v_nx ? hold_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_IDLE;
      s2_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
      s1_lane_q <= '1;
      s2_lane_q <= '1;
      hold_q    <= '0;
      out_q     <= '0;
      out_v_q   <= 1'b0;
    end else if (en) begin
      s1_op_q   <= cmd_op;
      s1_addr_q <= cmd_addr;
      s1_lane_q <= cmd_lane_n;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_lane_q <= s1_lane_q;
      hold_q    <= hold_nx;
      out_q     <= out_nx;
      out_v_q   <= out_v_nx;
    end
  end

  assign mem_raddr = s1_addr_q;
  assign mem_we    = en && (s2_op_q == OP_WRITE);
  assign mem_waddr = s2_addr_q;
  assign mem_wlane = ~s2_lane_q;
  assign mem_wdata = wdata;

  assign rvalid = out_v_q & ~out_en_n;
  assign rdata  = rvalid ? out_q : '0;

  assign st1_op   = s1_op_q;
  assign st1_addr = s1_addr_q;
  assign st2_op   = s2_op_q;
  assign out_live = out_v_q;

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              burst_adv,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic              en;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lane_n;
  logic              burst_live;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [WORD_W-1:0] mem_rdata, mem_wdata;
  logic              mem_we;
  logic [LANES-1:0]  mem_wlane;
  op_e               st1_op, st2_op;
  logic [ADDR_W-1:0] st1_addr;
  logic              out_live;

  assign en = ~clk_en_n;

  zbt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .burst_adv(burst_adv), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lane_n(cmd_lane_n),
    .burst_live(burst_live)
  );

  zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .wr_en(mem_we), .wr_addr(mem_waddr), .wr_lane(mem_wlane),
    .wr_data(mem_wdata), .rd_addr(mem_raddr), .rd_data(mem_rdata)
  );

  zbt_data_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lane_n(cmd_lane_n),
    .wdata(wdata), .out_en_n(out_en_n), .mem_rdata(mem_rdata),
    .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wlane(mem_wlane), .mem_wdata(mem_wdata),
    .st1_op(st1_op), .st1_addr(st1_addr), .st2_op(st2_op), .out_live(out_live),
    .rdata(rdata), .rvalid(rvalid)
  );

endmodule

// File: rtl/zbt_sram_core_chk.sv
module zbt_sram_core_chk
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              burst_adv,
  input logic              out_en_n,
  input logic              burst_live,
  input op_e               st1_op,
  input logic [ADDR_W-1:0] st1_addr,
  input op_e               st2_op,
  input logic              out_live,
  input logic [WORD_W-1:0] rdata,
  input logic              rvalid
);

  AST_OE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rvalid && rdata == '0));                                   // R8

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(out_live) && $stable(st1_op) && $stable(st1_addr)));  // R7

  AST_READ_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && st2_op == OP_READ) |=> out_live);                           // R2

  AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && st2_op != OP_READ) |=> !out_live);                          // R10

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && burst_live) |=>
      (st1_op != OP_IDLE &&
       st1_addr[ADDR_W-1:2] == $past(st1_addr[ADDR_W-1:2]) &&
       st1_addr[1:0] == $past(st1_addr[1:0]) + 2'd1));                         // R5

endmodule

bind zbt_sram_core zbt_sram_core_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .burst_adv(burst_adv),
  .out_en_n(out_en_n), .burst_live(burst_live), .st1_op(st1_op),
  .st1_addr(st1_addr), .st2_op(st2_op), .out_live(out_live),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/zbt_sram_core_bench.sv
`timescale 1ns/1ps
module zbt_sram_core_bench;

  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, cs0_n, cs1, cs2_n, burst_adv, wr_n, out_en_n;
  logic [1:0]  lane_wr_n;
  logic [AW-1:0] addr;
  logic [17:0] wdata, rdata;
  logic        rvalid;

  always #4 clk = ~clk;

  zbt_sram_core u_zbt_sram_core (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .burst_adv(burst_adv), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {bit v; bit wr; int a; bit [1:0] ln; bit [17:0] d;} mcmd_t;
  logic [17:0] ref_mem [int];
  mcmd_t m1, m2;
  bit    b_sel, b_wr;
  int    b_addr;
  bit    exp_v;
  bit [17:0] exp_d;

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [17:0] lane_merge(bit [17:0] old, bit [17:0] nw, bit [1:0] ln);
    bit [17:0] r = old;
    if (!ln[0]) r[8:0]  = nw[8:0];
    if (!ln[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  // One clock cycle: drive at negedge, model the edge, check 1 ns after it.
  task automatic cyc(input bit stall, input bit sel, input bit adv, input bit wn,
                     input bit [1:0] ln, input int a, input bit oen, input string tag);
    bit [17:0] plan_d;
    bit [17:0] ed;
    bit        ev;
    @(negedge clk);
    clk_en_n  = stall;
    burst_adv = adv;
    wr_n      = wn;
    lane_wr_n = ln;
    addr      = a[AW-1:0];
    out_en_n  = oen;
    if (sel) begin
      cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
    end else begin
      cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
      case ($urandom_range(2))
        0: cs0_n = 1'b1;
        1: cs1   = 1'b0;
        default: cs2_n = 1'b1;
      endcase
    end
    plan_d = 18'($urandom);
    wdata  = (m2.v && m2.wr) ? m2.d : 18'($urandom);
    @(posedge clk);
    #1;
    if (!stall) begin
      if (m2.v && m2.wr)
        ref_mem[m2.a] = lane_merge(ref_mem.exists(m2.a) ? ref_mem[m2.a] : 18'h0, wdata, m2.ln);
      exp_v = m2.v && !m2.wr;
      if (exp_v) exp_d = ref_mem[m2.a];
      m2 = m1;
      if (!adv) begin
        b_sel = sel; b_wr = !wn; b_addr = a;
      end else begin
        b_addr = (b_addr & ~3) | ((b_addr + 1) & 3);
      end
      m1 = '{b_sel, b_wr, b_addr, ln, plan_d};
    end
    ev = exp_v && !oen;
    ed = ev ? exp_d : 18'h0;
    chk(oen ? "R8 rvalid" : {tag, " rvalid"}, {17'h0, rvalid}, {17'h0, ev});
    chk(oen ? "R8 rdata" : {tag, " rdata"}, rdata, ed);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 0, 1'b0, tag);
  endtask

  task automatic wr_word(input int a, input bit [1:0] ln, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, ln, a, 1'b0, tag);
  endtask

  task automatic rd_word(input int a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, a, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m1 = '{0, 0, 0, 2'b11, 0};
    m2 = m1;
    b_sel = 0; b_wr = 0; b_addr = 0; exp_v = 0; exp_d = 0;
    rst_n = 1'b0; clk_en_n = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    burst_adv = 1'b0; wr_n = 1'b1; lane_wr_n = 2'b11; addr = '0; wdata = '0;
    out_en_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rvalid", {17'h0, rvalid}, 18'h0);
    chk("R1 rdata", rdata, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: preload a 64-word window with write bursts; wr_n and selects random on advances.
    for (int base = 0; base < 64; base += 4) begin
      wr_word(base, 2'b00, "R5");
      for (int k = 0; k < 3; k++)
        cyc(1'b0, 1'($urandom), 1'b1, 1'($urandom), 2'b00, $urandom_range(63), 1'b0, "R5");
    end
    idle("R10"); idle("R10");

    // R5: read burst starting mid-block wraps within the 4-word block.
    rd_word(18, "R5");
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 0, 1'b0, "R5");
    idle("R5"); idle("R5");

    // R4: lane a only, then lane b only.
    wr_word(5, 2'b10, "R4");
    wr_word(6, 2'b01, "R4");
    idle("R10"); idle("R10");
    rd_word(5, "R4"); rd_word(6, "R4");
    idle("R4"); idle("R4");

    // R9: read right after a write to the same address.
    wr_word(7, 2'b00, "R9");
    rd_word(7, "R9");
    idle("R9"); idle("R9");
    wr_word(8, 2'b01, "R9");
    rd_word(8, "R9");
    idle("R9"); idle("R9");

    // R3: alternate write/read back-to-back.
    for (int k = 0; k < 6; k++) begin
      wr_word(20 + k, 2'b00, "R3");
      rd_word(20 + k - 1, "R3");
    end
    idle("R3"); idle("R3");

    // R6: deselected write must not change the word.
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 9, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 9, 1'b0, "R6");
    idle("R6"); idle("R6");
    rd_word(9, "R6"); idle("R6"); idle("R6");

    // R7: stall while a read sits at the output.
    rd_word(3, "R7"); idle("R7"); idle("R7");
    for (int k = 0; k < 4; k++)
      cyc(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), $urandom_range(63), 1'b0, "R7");
    idle("R7");

    // R8: output enable high while data is valid.
    rd_word(4, "R8"); idle("R8");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 0, 1'b1, "R8");
    idle("R8");

    // R2: random mix.
    for (int k = 0; k < 3000; k++)
      cyc(($urandom_range(9) == 0), ($urandom_range(9) != 0), ($urandom_range(9) < 3),
          1'($urandom), 2'($urandom), $urandom_range(63), ($urandom_range(9) == 0), "R2");
    idle("R2"); idle("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule